// File: doc/BRIEF.md
# Interrupt Request Flag Controller

This block keeps one request flag for each of eleven interrupt sources of a small controller: two timer-1 compare channels, a timer-0 compare, the basic interval timer, serial transfer done, the watch timer, four external pins and an eight-bit key port. Internal sources arrive as one-cycle pulses. External pins and key inputs are first synchronized, then edge-detected. A flag that is pending and enabled takes part in a fixed-priority arbitration over nine service vectors. The winner is presented as a registered request and vector index.

The CPU acknowledges the vector it is serving, and the block then clears flags according to per-source rules. Most sources clear on acknowledge. The watch-timer flag and external pin 2 never do. On a vector that two sources share, the flag clears only when exactly one of the two is enabled, so that software can tell the origin by testing the flags when both are enabled. A one-bit register port lets software read any flag and write it to 0 or 1. Writing 1 raises a software interrupt.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, all flags read 0, `irq_req` is 0 and `irq_vec` is 0.
- R2: A pulse on `int_evt` bit b (0 timer-1 channel A, 1 timer-1 channel B, 2 timer-0, 3 basic timer, 4 serial, 5 watch) sets the flag of that source at the edge that samples it. `irq_req` and `irq_vec` reflect the set flag from that same edge.
- R3: Flag indices are 0 timer-1A, 1 timer-1B, 2 timer-0, 3 basic, 4 serial, 5 ext pin 3, 6 ext pin 0, 7 ext pin 1, 8 key, 9 watch, 10 ext pin 2. `reg_rdata` shows the flag selected by `reg_sel`. A write with `reg_wr` loads `reg_wdata` into that flag only, and a written 1 raises a request like a hardware event.
- R4: `irq_req` is registered as `gie` AND (any flag that is 1 with its `src_en` bit set). A pending flag whose enable is 0 stays set but raises no request.
- R5: Vectors are 0 {flags 0,1}, 1 {2}, 2 {3}, 3 {4}, 4 {5}, 5 {6,7}, 6 {8}, 7 {9}, 8 {10}. The lowest-numbered vector that has an enabled pending flag wins.
- R6: `irq_ack` while `irq_req` is 1 clears the enabled flag of a single-source vector (other than vectors 7 and 8) at that edge.
- R7: On an acknowledged shared vector (0 or 5), the enabled flag clears when only one of the two sources is enabled. When both are enabled, neither flag is cleared.
- R8: An acknowledge never clears flag 9 (watch) or flag 10 (ext pin 2). Only a software write clears them.
- R9: Pins 0..2 of `ext_pin` set their flags on one edge, rising when the `ext_rise_sel` bit is 1 and falling when it is 0. The other edge is ignored. A pin change sampled at edge a sets the flag at edge a+2.
- R10: Pin 3 of `ext_pin` sets flag 5 on both rising and falling edges, with the same latency as R9.
- R11: The key flag sets when any `key_pin` bit shows the edge selected by `key_rise_sel` (1 rising, 0 falling), with the same latency as R9.
- R12: A hardware set and a software write of 0 to the same flag in the same cycle leave the flag at 1.
- R13: While `irq_req` is 1, no acknowledge arrives, and the presented vector still has an enabled pending flag, `irq_vec` holds even if a higher-priority flag becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| int_evt | input | 6 | One-cycle event pulses from internal sources |
| ext_pin | input | 4 | External interrupt pins (0,1,2 single edge; 3 both edges) |
| ext_rise_sel | input | 3 | Edge select for ext pins 0..2: 1 rising, 0 falling |
| key_pin | input | KEY_W | Key-port inputs |
| key_rise_sel | input | 1 | Key edge select: 1 rising, 0 falling |
| src_en | input | 11 | Per-flag enable |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | CPU acknowledges the presented vector |
| reg_wr | input | 1 | Software write strobe |
| reg_sel | input | 4 | Flag index for read and write |
| reg_wdata | input | 1 | Value written to the selected flag |
| reg_rdata | output | 1 | Selected flag value (combinational) |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 4 | Winning vector index |

## Verification
Internal pulses, software writes and acknowledges act at the edge that samples them, so their results are due one cycle after the stimulus is applied. Pin and key edges pass two synchronizer stages and a history flop, so their results are due three cycles after the pin changes. The driver computes each due cycle from these latencies and queues the expected request, vector and selected flag value. The monitor compares them only in that cycle, on the falling clock edge, and holds every other input steady until the queue has drained.

// File: rtl/irq_flag_pkg.sv
`timescale 1ns/1ps
package irq_flag_pkg;
  localparam int NSRC     = 11;
  localparam int NVEC     = 9;
  localparam int EVT_W    = 6;
  localparam int EXT_W    = 4;
  localparam int VEC_W    = $clog2(NVEC);
  localparam int SEL_W    = $clog2(NSRC);
  localparam int VEC_SPAN = 1 << VEC_W;
  localparam int SEL_SPAN = 1 << SEL_W;

  localparam int SRC_T1A   = 0;
  localparam int SRC_T1B   = 1;
  localparam int SRC_T0    = 2;
  localparam int SRC_BT    = 3;
  localparam int SRC_SER   = 4;
  localparam int SRC_EXT3  = 5;
  localparam int SRC_EXT0  = 6;
  localparam int SRC_EXT1  = 7;
  localparam int SRC_KEY   = 8;
  localparam int SRC_WATCH = 9;
  localparam int SRC_EXT2  = 10;

  // Map a source flag to its service vector (lower vector = higher priority)
  function automatic logic [VEC_W-1:0] src_vec(input int s);
    case (s)
      SRC_T1A, SRC_T1B:   src_vec = VEC_W'(0);
      SRC_T0:             src_vec = VEC_W'(1);
      SRC_BT:             src_vec = VEC_W'(2);
      SRC_SER:            src_vec = VEC_W'(3);
      SRC_EXT3:           src_vec = VEC_W'(4);
      SRC_EXT0, SRC_EXT1: src_vec = VEC_W'(5);
      SRC_KEY:            src_vec = VEC_W'(6);
      SRC_WATCH:          src_vec = VEC_W'(7);
      default:            src_vec = VEC_W'(8);
    endcase
  endfunction

  // Flags that only software may clear
  function automatic logic src_sticky(input int s);
    src_sticky = (s == SRC_WATCH) || (s == SRC_EXT2);
  endfunction
endpackage

// File: rtl/irq_pin_edge.sv
`timescale 1ns/1ps
module irq_pin_edge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] hit
);
  logic [W-1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign hit[i] = (sync_q[i] & ~hist_q[i] & rise_en[i]) |
                    (~sync_q[i] & hist_q[i] & fall_en[i]);
  end
endmodule

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank
  import irq_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  hw_set,
  input  logic [NSRC-1:0]  src_en,
  input  logic             ack_ok,
  input  logic [VEC_W-1:0] ack_vec,
  input  logic             wr,
  input  logic [SEL_W-1:0] sel,
  input  logic             wdata,
  output logic [NSRC-1:0]  flag_q,
  output logic [NSRC-1:0]  flag_d
);
  logic [1:0]      en_cnt [VEC_SPAN];
  logic [NSRC-1:0] clr;
  logic [NSRC-1:0] wr_hit;
  logic            flag_upd;

  always_comb begin
    for (int v = 0; v < VEC_SPAN; v++) en_cnt[v] = 2'd0;
    for (int s = 0; s < NSRC; s++)
      en_cnt[src_vec(s)] = en_cnt[src_vec(s)] + 2'(src_en[s]);
  end

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      wr_hit[s] = wr && (sel == SEL_W'(s));
      clr[s]    = ack_ok && (src_vec(s) == ack_vec) && src_en[s] &&
                  !src_sticky(s) && (en_cnt[ack_vec] == 2'd1);
      if (hw_set[s])      flag_d[s] = 1'b1;
      else if (wr_hit[s]) flag_d[s] = wdata;
      else if (clr[s])    flag_d[s] = 1'b0;
      else                flag_d[s] = flag_q[s];
    end
    flag_upd = |(hw_set | wr_hit | clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= '0;
    else if (flag_upd) flag_q <= flag_d;
  end
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
  import irq_flag_pkg::*;
(
  input  logic [NSRC-1:0]     flag_n,
  input  logic [NSRC-1:0]     src_en,
  input  logic                gie,
  input  logic                req_q,
  input  logic                ack_ok,
  input  logic [VEC_W-1:0]    vec_q,
  output logic [VEC_SPAN-1:0] vpend,
  output logic                req_d,
  output logic [VEC_W-1:0]    vec_d
);
  logic [VEC_W-1:0] win;
  logic             hold;

  always_comb begin
    vpend = '0;
    for (int s = 0; s < NSRC; s++)
      vpend[src_vec(s)] = vpend[src_vec(s)] | (flag_n[s] & src_en[s]);
    win = '0;
    for (int v = NVEC - 1; v >= 0; v--)
      if (vpend[v]) win = VEC_W'(v);
    hold  = req_q && !ack_ok && vpend[vec_q];
    req_d = gie && (|vpend);
    vec_d = hold ? vec_q : win;
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
`timescale 1ns/1ps
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] int_evt,
  input  logic [EXT_W-1:0] ext_pin,
  input  logic [2:0]       ext_rise_sel,
  input  logic [KEY_W-1:0] key_pin,
  input  logic             key_rise_sel,
  input  logic [NSRC-1:0]  src_en,
  input  logic             gie,
  input  logic             irq_ack,
  input  logic             reg_wr,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             reg_wdata,
  output logic             reg_rdata,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  localparam int PIN_W = EXT_W + KEY_W;

  logic                rst_m, rst_q;
  logic [PIN_W-1:0]    pin_all, rise_en, fall_en, hit;
  logic [NSRC-1:0]     set_vec, flag_q, flag_d;
  logic [SEL_SPAN-1:0] flag_pad;
  logic [VEC_SPAN-1:0] vpend;
  logic                ack_ok, req_d, out_upd;
  logic [VEC_W-1:0]    vec_d;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  assign pin_all = {key_pin, ext_pin};
  assign rise_en = {{KEY_W{key_rise_sel}},  1'b1, ext_rise_sel};
  assign fall_en = {{KEY_W{~key_rise_sel}}, 1'b1, ~ext_rise_sel};

  irq_pin_edge #(.W(PIN_W)) u_edge (
    .clk     (clk),
    .rst_n   (rst_q),
    .pin     (pin_all),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .hit     (hit)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[SRC_T1A]   = int_evt[0];
    set_vec[SRC_T1B]   = int_evt[1];
    set_vec[SRC_T0]    = int_evt[2];
    set_vec[SRC_BT]    = int_evt[3];
    set_vec[SRC_SER]   = int_evt[4];
    set_vec[SRC_WATCH] = int_evt[5];
    set_vec[SRC_EXT0]  = hit[0];
    set_vec[SRC_EXT1]  = hit[1];
    set_vec[SRC_EXT2]  = hit[2];
    set_vec[SRC_EXT3]  = hit[3];
    set_vec[SRC_KEY]   = |hit[PIN_W-1:EXT_W];
  end

  assign ack_ok = irq_ack && irq_req;

  irq_flag_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_q),
    .hw_set  (set_vec),
    .src_en  (src_en),
    .ack_ok  (ack_ok),
    .ack_vec (irq_vec),
    .wr      (reg_wr),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .flag_q  (flag_q),
    .flag_d  (flag_d)
  );

  irq_arbiter u_arb (
    .flag_n (flag_d),
    .src_en (src_en),
    .gie    (gie),
    .req_q  (irq_req),
    .ack_ok (ack_ok),
    .vec_q  (irq_vec),
    .vpend  (vpend),
    .req_d  (req_d),
    .vec_d  (vec_d)
  );

  assign out_upd = (req_d != irq_req) || (vec_d != irq_vec);

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else if (out_upd) begin
      irq_req <= req_d;
      irq_vec <= vec_d;
    end
  end

  assign flag_pad  = SEL_SPAN'(flag_q);
  assign reg_rdata = flag_pad[reg_sel];
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
`timescale 1ns/1ps
module irq_flag_ctrl_chk
  import irq_flag_pkg::*;
(
  input logic                clk,
  input logic                rst_q,
  input logic                gie,
  input logic                irq_ack,
  input logic                irq_req,
  input logic [VEC_W-1:0]    irq_vec,
  input logic                reg_wr,
  input logic [SEL_W-1:0]    reg_sel,
  input logic [NSRC-1:0]     src_en,
  input logic [NSRC-1:0]     flag_q,
  input logic [NSRC-1:0]     set_vec,
  input logic [VEC_SPAN-1:0] vpend
);
  // R4: a request needs the global enable in the cycle it was formed
  a_r4_req_needs_gie: assert property (@(posedge clk) disable iff (!rst_q)
    irq_req |-> $past(gie));

  // R6: acknowledged timer-0 vector clears its flag
  a_r6_auto_clear: assert property (@(posedge clk) disable iff (!rst_q)
    (irq_ack && irq_req && irq_vec == VEC_W'(1) && !set_vec[SRC_T0] &&
     !(reg_wr && reg_sel == SEL_W'(SRC_T0)))
    |=> !flag_q[SRC_T0]);

  // R7: shared vector with both sources enabled keeps its flag
  a_r7_shared_keep: assert property (@(posedge clk) disable iff (!rst_q)
    (irq_ack && irq_req && irq_vec == VEC_W'(0) && src_en[SRC_T1A] &&
     src_en[SRC_T1B] && flag_q[SRC_T1A] &&
     !(reg_wr && reg_sel == SEL_W'(SRC_T1A)))
    |=> flag_q[SRC_T1A]);

  // R8: watch flag survives acknowledge
  a_r8_watch_sticky: assert property (@(posedge clk) disable iff (!rst_q)
    (irq_ack && flag_q[SRC_WATCH] && !(reg_wr && reg_sel == SEL_W'(SRC_WATCH)))
    |=> flag_q[SRC_WATCH]);

  // R12: every hardware set lands, whatever else happens that cycle
  a_r12_hw_wins: assert property (@(posedge clk) disable iff (!rst_q)
    (set_vec != '0) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

  // R13: presented vector holds while still pending and not acknowledged
  a_r13_vec_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (irq_req && !irq_ack && vpend[irq_vec]) |=> $stable(irq_vec));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
  .clk     (clk),
  .rst_q   (rst_q),
  .gie     (gie),
  .irq_ack (irq_ack),
  .irq_req (irq_req),
  .irq_vec (irq_vec),
  .reg_wr  (reg_wr),
  .reg_sel (reg_sel),
  .src_en  (src_en),
  .flag_q  (flag_q),
  .set_vec (set_vec),
  .vpend   (vpend)
);

// File: tb/irq_flag_ctrl_test.sv
`timescale 1ns/1ps
module irq_flag_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] int_evt;
  logic [3:0] ext_pin;
  logic [2:0] ext_rise_sel;
  logic [7:0] key_pin;
  logic       key_rise_sel;
  logic [10:0] src_en;
  logic       gie, irq_ack, reg_wr, reg_wdata;
  logic [3:0] reg_sel;
  logic       reg_rdata, irq_req;
  logic [3:0] irq_vec;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    int    due;
    bit    req;
    int    vec;
    bit    rd;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_flag_ctrl uut (
    .clk(clk), .rst_n(rst_n), .int_evt(int_evt), .ext_pin(ext_pin),
    .ext_rise_sel(ext_rise_sel), .key_pin(key_pin), .key_rise_sel(key_rise_sel),
    .src_en(src_en), .gie(gie), .irq_ack(irq_ack), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  // monitor: compare queued expectations in their due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (irq_req !== e.req || int'(irq_vec) != e.vec || reg_rdata !== e.rd) begin
        bad++;
        $display("FAIL %s: req=%0b vec=%0d rd=%0b expected req=%0b vec=%0d rd=%0b",
                 e.tag, irq_req, irq_vec, reg_rdata, e.req, e.vec, e.rd);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_in(int lat, bit r, int v, bit rd, string tag);
    exp_t e;
    e.due = cyc + lat; e.req = r; e.vec = v; e.rd = rd; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() > 0) step();
  endtask

  task automatic pulse(logic [5:0] m, int sel, bit r, int v, bit rd, string tag);
    reg_sel = 4'(sel);
    int_evt = m;
    expect_in(1, r, v, rd, tag);
    step();
    int_evt = '0;
    drain();
  endtask

  task automatic swr(int sel, bit val, bit r, int v, bit rd, string tag);
    reg_sel = 4'(sel); reg_wr = 1'b1; reg_wdata = val;
    expect_in(1, r, v, rd, tag);
    step();
    reg_wr = 1'b0;
    drain();
  endtask

  task automatic ack(bit r, int v, bit rd, string tag);
    irq_ack = 1'b1;
    expect_in(1, r, v, rd, tag);
    step();
    irq_ack = 1'b0;
    drain();
  endtask

  task automatic set_pin(int idx, bit val, int sel, bit r, int v, bit rd, string tag);
    reg_sel = 4'(sel);
    ext_pin[idx] = val;
    expect_in(3, r, v, rd, tag);
    drain();
  endtask

  task automatic set_key(int idx, bit val, bit r, int v, bit rd, string tag);
    reg_sel = 4'd8;
    key_pin[idx] = val;
    expect_in(3, r, v, rd, tag);
    drain();
  endtask

  initial begin
    rst_n = 1'b0; int_evt = '0; ext_pin = '0; ext_rise_sel = 3'b110;
    key_pin = '0; key_rise_sel = 1'b0; src_en = '1; gie = 1'b1;
    irq_ack = 1'b0; reg_wr = 1'b0; reg_sel = '0; reg_wdata = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    expect_in(0, 0, 0, 0, "R1 reset");
    drain();

    // R2 internal event, R6 auto clear
    pulse(6'b000100, 2, 1, 1, 1, "R2 timer0 event");
    ack(0, 0, 0, "R6 timer0 ack clears");

    // R3 software set and clear
    swr(4, 1, 1, 3, 1, "R3 sw set serial");
    swr(4, 0, 0, 0, 0, "R3 sw clear serial");

    // R4 global and source enables
    gie = 1'b0;
    swr(4, 1, 0, 3, 1, "R4 gie off no req");
    gie = 1'b1;
    expect_in(1, 1, 3, 1, "R4 gie on req");
    step(); drain();
    src_en[4] = 1'b0;
    expect_in(1, 0, 0, 1, "R4 source disabled");
    step(); drain();
    src_en[4] = 1'b1;
    swr(4, 0, 0, 0, 0, "R3 cleanup");

    // R5 priority on simultaneous events
    pulse(6'b011000, 3, 1, 2, 1, "R5 basic beats serial");
    ack(1, 3, 0, "R5 serial next");
    ack(0, 0, 0, "R6 serial cleared");

    // R13 vector hold, then priority after ack
    swr(8, 1, 1, 6, 1, "R3 sw set key");
    swr(3, 1, 1, 6, 1, "R13 vector held");
    ack(1, 2, 1, "R5 basic after key ack");
    ack(0, 0, 0, "R6 basic cleared");

    // R7 shared vector
    src_en[1] = 1'b0;
    pulse(6'b000001, 0, 1, 0, 1, "R2 timer1A event");
    ack(0, 0, 0, "R7 single enabled clears");
    src_en[1] = 1'b1;
    pulse(6'b000001, 0, 1, 0, 1, "R2 timer1A event both en");
    ack(1, 0, 1, "R7 both enabled keep");
    swr(0, 0, 0, 0, 0, "R3 sw clear shared");

    // R8 watch sticky
    pulse(6'b100000, 9, 1, 7, 1, "R2 watch event");
    ack(1, 7, 1, "R8 watch not cleared");
    swr(9, 0, 0, 0, 0, "R8 watch sw clear");

    // R9 ext pin 2 rising, R8 sticky
    set_pin(2, 1, 10, 1, 8, 1, "R9 ext2 rising");
    ack(1, 8, 1, "R8 ext2 not cleared");
    swr(10, 0, 0, 0, 0, "R8 ext2 sw clear");
    set_pin(2, 0, 10, 0, 0, 0, "R9 ext2 falling ignored");

    // R9 ext pin 0 falling selected
    set_pin(0, 1, 6, 0, 0, 0, "R9 ext0 rising ignored");
    set_pin(0, 0, 6, 1, 5, 1, "R9 ext0 falling");
    ack(1, 5, 1, "R7 ext shared both keep");
    swr(6, 0, 0, 0, 0, "R3 sw clear ext0");

    // R10 ext pin 3 both edges
    set_pin(3, 1, 5, 1, 4, 1, "R10 ext3 rising");
    ack(0, 0, 0, "R6 ext3 cleared");
    set_pin(3, 0, 5, 1, 4, 1, "R10 ext3 falling");
    ack(0, 0, 0, "R6 ext3 cleared again");

    // R11 key port falling selected
    set_key(5, 1, 0, 0, 0, "R11 key rising ignored");
    set_key(5, 0, 1, 6, 1, "R11 key falling");
    ack(0, 0, 0, "R6 key cleared");

    // R12 hw set beats sw clear
    reg_sel = 4'd2; reg_wr = 1'b1; reg_wdata = 1'b0; int_evt = 6'b000100;
    expect_in(1, 1, 1, 1, "R12 hw set wins");
    step();
    reg_wr = 1'b0; int_evt = '0;
    drain();
    ack(0, 0, 0, "R6 timer0 cleared");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule